// File: doc/BRIEF.md
# I3C Target Reset Action Controller

This block chooses the reset response of an I3C target when a Target Reset Pattern is reported on the bus. A CCC decoder upstream delivers the 8-bit defining byte of a reset-action write, whether broadcast or direct. The block stores that byte, and software can read it back. A separate pattern detector raises a single-cycle pulse when the reset pattern is seen. On that pulse the block decodes the stored byte. It then issues a module reset request or a whole-device reset request, or it takes no action. In every case it restores the stored byte to its empty value, 0xFF.

If a reset pattern arrives and no reset-action write came before it, the block escalates. The first unaccompanied pattern gives a module reset. The next consecutive one gives a device reset, and the escalation count then starts again. After a module reset the target is held quiet: it has released the bus and ignores traffic until a bus-idle pulse arrives. An interrupt flag marks every pattern that was handled, and software clears it by writing one.

Top module: `tgt_reset_action`

## Requirements
- R1: After reset, action_byte is 0xFF, both reset requests are low, rst_irq is low and target_quiesced is low.
- R2: A cfg_wr_valid pulse with no rst_pattern in the same cycle, taken while the target is not quiesced, loads cfg_wr_byte into action_byte. The new value is visible on the cycle after the write.
- R3: A pattern with stored byte 0x00 raises no request and clears the escalation count, so the next unaccompanied pattern gives a module reset.
- R4: A pattern with stored byte 0x01 pulses module_reset_req, sets target_quiesced and clears the escalation count.
- R5: A pattern with stored byte 0x02 pulses device_reset_req and leaves target_quiesced unchanged.
- R6: With stored byte 0xFF, the first pattern pulses module_reset_req and the second consecutive one pulses device_reset_req. Each module reset sets target_quiesced. The count then restarts, so a third pattern is a module reset again.
- R7: A stored byte in the range 0x03 to 0xFE raises no request and clears the escalation count.
- R8: On the cycle after any pattern, action_byte reads 0xFF.
- R9: When a write and a pattern occur in the same cycle, the pattern is decoded with the byte stored before that cycle. The written byte is then discarded, and action_byte reads 0xFF.
- R10: target_quiesced falls only on a bus_idle pulse in a cycle after the one in which the module reset was issued. A bus_idle pulse in the same cycle as the pattern is ignored. Writes are ignored while the target is quiesced.
- R11: rst_irq is set on every pattern and cleared by irq_clear. If both arrive in the same cycle, the set wins.
- R12: Each reset request is high for exactly the one cycle after its pattern, and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_valid | input | 1 | Pulse: reset-action defining byte received |
| cfg_wr_byte | input | 8 | Defining byte carried by the write |
| rst_pattern | input | 1 | Pulse: Target Reset Pattern detected |
| bus_idle | input | 1 | Pulse: bus idle condition detected |
| irq_clear | input | 1 | Write-one-to-clear for rst_irq |
| action_byte | output | 8 | Stored defining byte, readable by software |
| module_reset_req | output | 1 | One-cycle request to reset the target module |
| device_reset_req | output | 1 | One-cycle request to reset the whole device |
| target_quiesced | output | 1 | Target is idle, has released the bus and ignores traffic |
| rst_irq | output | 1 | Reset-pattern interrupt flag |

## Verification
Every result passes through one register stage. A write, a pattern, a bus-idle pulse or a clear sampled at a rising edge shows up on the outputs right after that same edge. The bench drives each input pulse on a falling edge and removes it on the next falling edge, then samples the outputs at that second falling edge. That point lies half a cycle after the edge that acted on the pulse. Request pulses are checked again one cycle later to confirm that they have dropped. Scenarios that depend on the escalation count begin with a fresh reset, so that the count they expect is known.

// File: rtl/tgt_reset_pkg.sv
package tgt_reset_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_NONE   = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_MODULE = 8'h01;
    localparam logic [BYTE_W-1:0] CODE_DEVICE = 8'h02;
    localparam logic [BYTE_W-1:0] CODE_EMPTY  = 8'hFF;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_MODULE = 2'd1,
        ACT_DEVICE = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        ESC_HOLD = 2'd0,
        ESC_INC  = 2'd1,
        ESC_CLR  = 2'd2
    } esc_op_e;

endpackage

// File: rtl/tgt_rst_decode.sv
module tgt_rst_decode
    import tgt_reset_pkg::*;
#(
    parameter int ESC_LIMIT = 2,
    parameter int CNT_W     = 2
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output act_e              action_o,
    output esc_op_e           esc_op_o
);

    always_comb begin
        action_o = ACT_NONE;
        esc_op_o = ESC_CLR;
        if (byte_i == CODE_EMPTY) begin
            // unaccompanied pattern: escalate up to the limit
            if ((int'(cnt_i) + 1) >= ESC_LIMIT) begin
                action_o = ACT_DEVICE;
                esc_op_o = ESC_CLR;
            end else begin
                action_o = ACT_MODULE;
                esc_op_o = ESC_INC;
            end
        end else if (byte_i == CODE_MODULE) begin
            action_o = ACT_MODULE;
        end else if (byte_i == CODE_DEVICE) begin
            action_o = ACT_DEVICE;
        end else begin
            // CODE_NONE and every unassigned value: no action
            action_o = ACT_NONE;
        end
    end

endmodule

// File: rtl/tgt_rst_escalate.sv
module tgt_rst_escalate
    import tgt_reset_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  esc_op_e          op_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire_i) begin
            case (op_i)
                ESC_INC: cnt_d = cnt_q + 1'b1;
                ESC_CLR: cnt_d = '0;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tgt_rst_quiesce.sv
module tgt_rst_quiesce (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic bus_idle_i,
    output logic quiet_o
);

    logic quiet_d, quiet_q;

    always_comb begin
        quiet_d = quiet_q;
        if (enter_i) begin
            // idle seen in the issuing cycle does not count
            quiet_d = 1'b1;
        end else if (quiet_q && bus_idle_i) begin
            quiet_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) quiet_q <= 1'b0;
        else        quiet_q <= quiet_d;
    end

    assign quiet_o = quiet_q;

endmodule

// File: rtl/tgt_reset_action.sv
module tgt_reset_action
    import tgt_reset_pkg::*;
#(
    parameter int ESC_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_valid,
    input  logic [BYTE_W-1:0] cfg_wr_byte,
    input  logic              rst_pattern,
    input  logic              bus_idle,
    input  logic              irq_clear,
    output logic [BYTE_W-1:0] action_byte,
    output logic              module_reset_req,
    output logic              device_reset_req,
    output logic              target_quiesced,
    output logic              rst_irq
);

    localparam int CNT_W = (ESC_LIMIT < 2) ? 1 : $clog2(ESC_LIMIT + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] def_byte;
        logic              mod_req;
        logic              dev_req;
        logic              irq;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [CNT_W-1:0]  esc_cnt;
    act_e              act;
    esc_op_e           esc_op;
    logic              quiet;

    tgt_rst_decode #(
        .ESC_LIMIT (ESC_LIMIT),
        .CNT_W     (CNT_W)
    ) u_dec (
        .byte_i   (ctl_q.def_byte),
        .cnt_i    (esc_cnt),
        .action_o (act),
        .esc_op_o (esc_op)
    );

    tgt_rst_escalate #(
        .CNT_W (CNT_W)
    ) u_esc (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (rst_pattern),
        .op_i   (esc_op),
        .cnt_o  (esc_cnt)
    );

    tgt_rst_quiesce u_quiet (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (rst_pattern && (act == ACT_MODULE)),
        .bus_idle_i (bus_idle),
        .quiet_o    (quiet)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.mod_req = 1'b0;
        ctl_d.dev_req = 1'b0;
        if (rst_pattern) begin
            // decode uses the byte held before this cycle; any write now is dropped
            ctl_d.mod_req  = (act == ACT_MODULE);
            ctl_d.dev_req  = (act == ACT_DEVICE);
            ctl_d.def_byte = CODE_EMPTY;
            ctl_d.irq      = 1'b1;
        end else begin
            if (cfg_wr_valid && !quiet) begin
                ctl_d.def_byte = cfg_wr_byte;
            end
            if (irq_clear) begin
                ctl_d.irq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.def_byte <= CODE_EMPTY;
            ctl_q.mod_req  <= 1'b0;
            ctl_q.dev_req  <= 1'b0;
            ctl_q.irq      <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign action_byte      = ctl_q.def_byte;
    assign module_reset_req = ctl_q.mod_req;
    assign device_reset_req = ctl_q.dev_req;
    assign target_quiesced  = quiet;
    assign rst_irq          = ctl_q.irq;

endmodule

// File: rtl/tgt_reset_action_chk.sv
module tgt_reset_action_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr_valid,
    input logic [7:0] cfg_wr_byte,
    input logic       rst_pattern,
    input logic       bus_idle,
    input logic       irq_clear,
    input logic [7:0] action_byte,
    input logic       module_reset_req,
    input logic       device_reset_req,
    input logic       target_quiesced,
    input logic       rst_irq
);

    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_valid && !rst_pattern && !target_quiesced) |=> (action_byte == $past(cfg_wr_byte)));

    a_r5_device_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pattern && action_byte == 8'h02) |=> device_reset_req);

    a_r3_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pattern && action_byte == 8'h00) |=> (!device_reset_req && !module_reset_req));

    a_r8_byte_restored: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pattern |=> (action_byte == 8'hFF));

    a_r10_quiet_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(target_quiesced) |-> module_reset_req);

    a_r10_quiet_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (target_quiesced && bus_idle && !rst_pattern) |=> !target_quiesced);

    a_r11_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pattern |=> rst_irq);

    a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !rst_pattern) |=> !rst_irq);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({module_reset_req, device_reset_req}));

    a_r12_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (module_reset_req || device_reset_req) |-> $past(rst_pattern));

endmodule

bind tgt_reset_action tgt_reset_action_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_wr_valid     (cfg_wr_valid),
    .cfg_wr_byte      (cfg_wr_byte),
    .rst_pattern      (rst_pattern),
    .bus_idle         (bus_idle),
    .irq_clear        (irq_clear),
    .action_byte      (action_byte),
    .module_reset_req (module_reset_req),
    .device_reset_req (device_reset_req),
    .target_quiesced  (target_quiesced),
    .rst_irq          (rst_irq)
);

// File: tb/tgt_reset_action_test.sv
module tgt_reset_action_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_valid = 1'b0;
    logic [7:0] cfg_wr_byte = 8'h00;
    logic       rst_pattern = 1'b0;
    logic       bus_idle = 1'b0;
    logic       irq_clear = 1'b0;
    logic [7:0] action_byte;
    logic       module_reset_req;
    logic       device_reset_req;
    logic       target_quiesced;
    logic       rst_irq;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tgt_reset_action uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_wr_valid     (cfg_wr_valid),
        .cfg_wr_byte      (cfg_wr_byte),
        .rst_pattern      (rst_pattern),
        .bus_idle         (bus_idle),
        .irq_clear        (irq_clear),
        .action_byte      (action_byte),
        .module_reset_req (module_reset_req),
        .device_reset_req (device_reset_req),
        .target_quiesced  (target_quiesced),
        .rst_irq          (rst_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one-cycle stimulus, outputs sampled half a cycle after the acting edge
    task automatic drive(input logic pat, input logic wr, input logic [7:0] b,
                         input logic idle, input logic clr);
        @(negedge clk);
        rst_pattern  = pat;
        cfg_wr_valid = wr;
        cfg_wr_byte  = b;
        bus_idle     = idle;
        irq_clear    = clr;
        @(negedge clk);
        rst_pattern  = 1'b0;
        cfg_wr_valid = 1'b0;
        bus_idle     = 1'b0;
        irq_clear    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 byte", action_byte, 8'hFF);
        check("R1 mod", module_reset_req, 0);
        check("R1 dev", device_reset_req, 0);
        check("R1 irq", rst_irq, 0);
        check("R1 quiet", target_quiesced, 0);
    endtask

    task automatic t_write();
        do_reset();
        drive(0, 1, 8'h5A, 0, 0);
        check("R2 load", action_byte, 8'h5A);
        drive(0, 1, 8'hC3, 0, 0);
        check("R2 reload", action_byte, 8'hC3);
    endtask

    task automatic t_none_code();
        do_reset();
        drive(1, 0, 8'h00, 0, 0);            // unaccompanied -> module, count 1
        drive(0, 0, 8'h00, 1, 0);            // leave quiet state
        drive(0, 1, 8'h00, 0, 0);
        drive(1, 0, 8'h00, 0, 0);
        check("R3 no mod", module_reset_req, 0);
        check("R3 no dev", device_reset_req, 0);
        drive(1, 0, 8'h00, 0, 0);            // count was cleared
        check("R3 cleared count mod", module_reset_req, 1);
        check("R3 cleared count dev", device_reset_req, 0);
    endtask

    task automatic t_module_code();
        do_reset();
        drive(1, 0, 8'h00, 0, 0);            // count 1
        drive(0, 0, 8'h00, 1, 0);
        drive(0, 1, 8'h01, 0, 0);
        drive(1, 0, 8'h00, 0, 0);
        check("R4 mod", module_reset_req, 1);
        check("R4 quiet", target_quiesced, 1);
        check("R8 byte", action_byte, 8'hFF);
        @(negedge clk);
        check("R12 mod drops", module_reset_req, 0);
        drive(0, 0, 8'h00, 1, 0);
        drive(1, 0, 8'h00, 0, 0);
        check("R4 cleared count mod", module_reset_req, 1);
        check("R4 cleared count dev", device_reset_req, 0);
    endtask

    task automatic t_device_code();
        do_reset();
        drive(0, 1, 8'h02, 0, 0);
        drive(1, 0, 8'h00, 0, 0);
        check("R5 dev", device_reset_req, 1);
        check("R12 excl", module_reset_req, 0);
        check("R5 no quiet", target_quiesced, 0);
        check("R8 byte", action_byte, 8'hFF);
        @(negedge clk);
        check("R12 dev drops", device_reset_req, 0);
    endtask

    task automatic t_escalate();
        do_reset();
        drive(1, 0, 8'h00, 0, 0);
        check("R6 first mod", module_reset_req, 1);
        check("R6 first quiet", target_quiesced, 1);
        drive(0, 0, 8'h00, 1, 0);
        drive(1, 0, 8'h00, 0, 0);
        check("R6 second dev", device_reset_req, 1);
        check("R6 second no mod", module_reset_req, 0);
        drive(1, 0, 8'h00, 0, 0);
        check("R6 third mod", module_reset_req, 1);
    endtask

    task automatic t_other_code();
        do_reset();
        drive(1, 0, 8'h00, 0, 0);            // count 1
        drive(0, 0, 8'h00, 1, 0);
        drive(0, 1, 8'h7E, 0, 0);
        drive(1, 0, 8'h00, 0, 0);
        check("R7 no mod", module_reset_req, 0);
        check("R7 no dev", device_reset_req, 0);
        drive(1, 0, 8'h00, 0, 0);
        check("R7 cleared count", module_reset_req, 1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        drive(0, 1, 8'h02, 0, 0);
        drive(1, 1, 8'h01, 0, 0);
        check("R9 old byte dev", device_reset_req, 1);
        check("R9 not new mod", module_reset_req, 0);
        check("R9 discarded", action_byte, 8'hFF);
    endtask

    task automatic t_quiesce();
        do_reset();
        drive(1, 0, 8'h00, 1, 0);            // idle in issuing cycle
        check("R10 same-cycle idle ignored", target_quiesced, 1);
        drive(0, 1, 8'h02, 0, 0);
        check("R10 write ignored", action_byte, 8'hFF);
        drive(0, 0, 8'h00, 0, 0);
        check("R10 holds", target_quiesced, 1);
        drive(0, 0, 8'h00, 1, 0);
        check("R10 exit", target_quiesced, 0);
    endtask

    task automatic t_irq();
        do_reset();
        drive(1, 0, 8'h00, 0, 0);
        check("R11 set", rst_irq, 1);
        drive(0, 0, 8'h00, 0, 0);
        check("R11 sticky", rst_irq, 1);
        drive(0, 0, 8'h00, 0, 1);
        check("R11 clear", rst_irq, 0);
        drive(1, 0, 8'h00, 0, 1);
        check("R11 set wins", rst_irq, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL R0 watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_write();
        t_none_code();
        t_module_code();
        t_device_code();
        t_escalate();
        t_other_code();
        t_same_cycle();
        t_quiesce();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule